// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block sits between a processor load/store port and a slower memory that moves one 32-bit word per request/acknowledge transfer. It holds eight lines of four words each, over a 10-bit byte address. Every line has a tag, a valid flag and a dirty flag. A load or store that finds its line completes without touching memory. The load data appears one cycle after the request.

On a miss the block raises a stall toward the processor. If the line at the requested index holds modified data, the four words of that line go back to memory first. The full four-word block that holds the requested word is then read in. When the fill is done the stall drops, and the processor, which has held its request, completes it as a hit. A store miss therefore fetches the block first and then merges the store into it. Stores that hit change only the cached copy.

Top module: `dmc_top`

## Requirements
- R1: The byte address splits as tag = bits [9:7], index = bits [6:4], word within the block = bits [3:2]. An access hits only when the line at the index is valid and its stored tag equals the address tag. Any other access is a miss.
- R2: A hit keeps `cpu_stall` at 0 and issues no memory transfer. It raises `cpu_rvalid` for one cycle in the cycle after the request. For a load, `cpu_rdata` then holds the addressed word.
- R3: On a miss, `cpu_stall` is 1 from the cycle the miss is seen until the fill completes. The fill reads the four words of the requested block in the order word 0, 1, 2, 3. The memory address of each word is {tag, index, word, 2'b00}. `mem_req` is only high while `cpu_stall` is high.
- R4: A store hit writes the word in the cache only. Memory keeps its old value, and the line becomes dirty.
- R5: When the line at a missed index is valid and dirty, its four words are written to memory at the addresses of its old tag, in word order 0 to 3, before the fill starts. A freshly filled line is clean.
- R6: When the line at a missed index is clean or invalid, no memory write occurs and the fill begins at once.
- R7: A store miss allocates. The block is fetched, the store word is merged into it, and the line is dirty. The other three words keep their memory values.
- R8: Reset (`rst_n` = 0) clears every valid and dirty flag and drives `cpu_stall`, `cpu_rvalid` and `mem_req` to 0.
- R9: While `mem_req` is 1 and `mem_ack` is 0, the request, its direction and its address stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 10 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_stall | output | 1 | Access not yet completed |
| cpu_rvalid | output | 1 | Access completed in the previous cycle |
| cpu_rdata | output | 32 | Load data |
| mem_req | output | 1 | Memory word transfer request |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 10 | Word-aligned byte address of the transfer |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory accepts or completes the current word |
| mem_rdata | input | 32 | Fill data, valid with `mem_ack` |

## Verification
The assertions check four behaviours on every cycle. A filled line ends valid and clean, and a store hit leaves its line dirty. Memory transfers happen only while the processor is stalled, and a stall is never followed by a completion pulse. A pending memory request holds still until it is acknowledged. The bench scenarios are needed to show the rest: the data values returned, the word order and addresses of fills and write-backs, whether a write-back is taken or skipped, that memory keeps stale data after a store hit, and that reset discards dirty lines.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_array.sv
module dmc_tag_array #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             set_dirty,
  input  logic [IDX_W-1:0] dirty_idx
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q, valid_d;
  logic [LINES-1:0] dirty_q, dirty_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (fill_en) begin
      valid_d[fill_idx] = 1'b1;
      dirty_d[fill_idx] = 1'b0;
    end
    if (set_dirty) begin
      dirty_d[dirty_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_idx] <= fill_tag;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

  // R5: a line that has just been filled is valid and clean
  assert_fill_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));

  // R4: a store hit leaves its line dirty
  assert_store_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_dirty |=> dirty_q[$past(dirty_idx)]);
endmodule

// File: rtl/dmc_data_array.sv
module dmc_data_array #(
  parameter int IDX_W  = 3,
  parameter int WRD_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [WRD_W-1:0]  rd_word,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WRD_W-1:0]  wr_word,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int ENTRIES = 1 << (IDX_W + WRD_W);

  logic [DATA_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem_q[{wr_idx, wr_word}] <= wr_data;
    end
  end

  assign rd_data = mem_q[{rd_idx, rd_word}];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int TAG_W = 3,
  parameter int WRD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_req,
  input  logic             hit,
  input  logic             victim_dirty,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [TAG_W-1:0] req_tag,
  input  logic [TAG_W-1:0] old_tag,
  input  logic             mem_ack,
  output dmc_state_e       state,
  output logic [WRD_W-1:0] cnt,
  output logic [IDX_W-1:0] lat_idx,
  output logic [TAG_W-1:0] lat_new_tag,
  output logic [TAG_W-1:0] lat_old_tag,
  output logic             stall,
  output logic             accept,
  output logic             fill_wr,
  output logic             fill_last
);
  localparam logic [WRD_W-1:0] LAST = '1;

  dmc_state_e       state_q, state_d;
  logic [WRD_W-1:0] cnt_q, cnt_d;
  logic             miss;
  logic             at_last;

  assign miss    = (state_q == ST_IDLE) && cpu_req && !hit;
  assign at_last = (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (miss) begin
          state_d = victim_dirty ? ST_WBACK : ST_FILL;
        end
      end
      ST_WBACK: begin
        if (mem_ack) begin
          cnt_d = at_last ? '0 : cnt_q + 1'b1;
          if (at_last) begin
            state_d = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        if (mem_ack) begin
          cnt_d = at_last ? '0 : cnt_q + 1'b1;
          if (at_last) begin
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (miss) begin
      lat_idx     <= req_idx;
      lat_new_tag <= req_tag;
      lat_old_tag <= old_tag;
    end
  end

  assign state     = state_q;
  assign cnt       = cnt_q;
  assign stall     = (state_q != ST_IDLE) || miss;
  assign accept    = (state_q == ST_IDLE) && cpu_req && hit;
  assign fill_wr   = (state_q == ST_FILL) && mem_ack;
  assign fill_last = fill_wr && at_last;
endmodule

// File: rtl/dmc_top.sv
module dmc_top
  import dmc_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cpu_req,
  input  logic                           cpu_we,
  input  logic [TAG_W+IDX_W+OFF_W-1:0]   cpu_addr,
  input  logic [DATA_W-1:0]              cpu_wdata,
  output logic                           cpu_stall,
  output logic                           cpu_rvalid,
  output logic [DATA_W-1:0]              cpu_rdata,
  output logic                           mem_req,
  output logic                           mem_we,
  output logic [TAG_W+IDX_W+OFF_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]              mem_wdata,
  input  logic                           mem_ack,
  input  logic [DATA_W-1:0]              mem_rdata
);
  localparam int BYTE_W = $clog2(DATA_W / 8);
  localparam int WRD_W  = OFF_W - BYTE_W;

  logic [TAG_W-1:0] req_tag;
  logic [IDX_W-1:0] req_idx;
  logic [WRD_W-1:0] req_word;

  assign req_tag  = cpu_addr[OFF_W+IDX_W +: TAG_W];
  assign req_idx  = cpu_addr[OFF_W +: IDX_W];
  assign req_word = cpu_addr[BYTE_W +: WRD_W];

  dmc_state_e       state;
  logic [WRD_W-1:0] cnt;
  logic [IDX_W-1:0] lat_idx;
  logic [TAG_W-1:0] lat_new_tag, lat_old_tag;
  logic             accept, fill_wr, fill_last;
  logic             line_valid, line_dirty, hit;
  logic [TAG_W-1:0] line_tag;
  logic [IDX_W-1:0] arr_rd_idx, arr_wr_idx;
  logic [WRD_W-1:0] arr_rd_word, arr_wr_word;
  logic [DATA_W-1:0] arr_rd_data, arr_wr_data;
  logic             arr_wr_en;
  logic             rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign hit = line_valid && (line_tag == req_tag);

  dmc_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (req_idx),
    .rd_valid  (line_valid),
    .rd_dirty  (line_dirty),
    .rd_tag    (line_tag),
    .fill_en   (fill_last),
    .fill_idx  (lat_idx),
    .fill_tag  (lat_new_tag),
    .set_dirty (accept && cpu_we),
    .dirty_idx (req_idx)
  );

  dmc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .WRD_W(WRD_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_req      (cpu_req),
    .hit          (hit),
    .victim_dirty (line_valid && line_dirty),
    .req_idx      (req_idx),
    .req_tag      (req_tag),
    .old_tag      (line_tag),
    .mem_ack      (mem_ack),
    .state        (state),
    .cnt          (cnt),
    .lat_idx      (lat_idx),
    .lat_new_tag  (lat_new_tag),
    .lat_old_tag  (lat_old_tag),
    .stall        (cpu_stall),
    .accept       (accept),
    .fill_wr      (fill_wr),
    .fill_last    (fill_last)
  );

  always_comb begin
    arr_rd_idx  = req_idx;
    arr_rd_word = req_word;
    if (state == ST_WBACK) begin
      arr_rd_idx  = lat_idx;
      arr_rd_word = cnt;
    end
  end

  always_comb begin
    arr_wr_en   = accept && cpu_we;
    arr_wr_idx  = req_idx;
    arr_wr_word = req_word;
    arr_wr_data = cpu_wdata;
    if (fill_wr) begin
      arr_wr_en   = 1'b1;
      arr_wr_idx  = lat_idx;
      arr_wr_word = cnt;
      arr_wr_data = mem_rdata;
    end
  end

  dmc_data_array #(.IDX_W(IDX_W), .WRD_W(WRD_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rd_idx  (arr_rd_idx),
    .rd_word (arr_rd_word),
    .rd_data (arr_rd_data),
    .wr_en   (arr_wr_en),
    .wr_idx  (arr_wr_idx),
    .wr_word (arr_wr_word),
    .wr_data (arr_wr_data)
  );

  assign mem_req   = (state != ST_IDLE);
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = {(state == ST_WBACK) ? lat_old_tag : lat_new_tag,
                      lat_idx, cnt, {BYTE_W{1'b0}}};
  assign mem_wdata = arr_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= accept;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !cpu_we) begin
      rdata_q <= arr_rd_data;
    end
  end

  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;

  // R3: memory traffic only while the processor is held
  assert_mem_only_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_stall);

  // R2: a stalled cycle is never followed by a completion pulse
  assert_no_rvalid_after_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_stall |=> !cpu_rvalid);

  // R9: an unacknowledged request holds still
  assert_req_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

// File: tb/tb_dmc_top.sv
module tb_dmc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [9:0]  cpu_addr;
  logic [31:0] cpu_wdata;
  logic        cpu_stall, cpu_rvalid;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [9:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem_model [256];
  int          wr_cnt, rd_cnt, hold_viol;
  logic [9:0]  wr_addr_log [8];
  logic [31:0] wr_data_log [8];
  logic [9:0]  rd_addr_log [8];
  logic        prev_pend;
  logic [9:0]  prev_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmc_top dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] init_val(input logic [9:0] a);
    return 32'h5A00_0000 | {24'd0, a[9:2]};
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem_model[i] = 32'h5A00_0000 | i;
  end

  // memory model: acknowledges every other cycle, logs each transfer
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      prev_pend <= 1'b0;
      prev_addr <= '0;
    end else begin
      if (prev_pend && (!mem_req || mem_addr != prev_addr)) hold_viol = hold_viol + 1;
      prev_pend <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      mem_ack   <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) mem_rdata <= mem_model[mem_addr[9:2]];
      if (mem_req && mem_ack) begin
        if (mem_we) begin
          mem_model[mem_addr[9:2]] <= mem_wdata;
          if (wr_cnt < 8) begin
            wr_addr_log[wr_cnt] = mem_addr;
            wr_data_log[wr_cnt] = mem_wdata;
          end
          wr_cnt = wr_cnt + 1;
        end else begin
          if (rd_cnt < 8) rd_addr_log[rd_cnt] = mem_addr;
          rd_cnt = rd_cnt + 1;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [9:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit stalled, output bit rv);
    wr_cnt = 0;
    rd_cnt = 0;
    stalled = 1'b0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    #1;
    while (cpu_stall) begin
      stalled = 1'b1;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    rd = cpu_rdata;
    rv = cpu_rvalid;
  endtask

  function automatic bit block_order(input logic [9:0] base, input bit wlog);
    for (int i = 0; i < 4; i++) begin
      logic [9:0] exp_a;
      exp_a = base + 10'(4 * i);
      if (wlog && wr_addr_log[i] != exp_a) return 1'b0;
      if (!wlog && rd_addr_log[i] != exp_a) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic t_reset_state;
    check(!cpu_stall, "R8 stall after reset", 32'(cpu_stall), 0);
    check(!cpu_rvalid, "R8 rvalid after reset", 32'(cpu_rvalid), 0);
    check(!mem_req, "R8 mem_req after reset", 32'(mem_req), 0);
  endtask

  task automatic t_read_miss;
    logic [31:0] rd; bit st, rv;
    access(1'b0, 10'h018, '0, rd, st, rv);
    check(st, "R3 read miss stalls", 32'(st), 1);
    check(rd == init_val(10'h018), "R1 miss data", rd, init_val(10'h018));
    check(rd_cnt == 4 && wr_cnt == 0, "R6 fill only, no write-back", 32'(rd_cnt*16+wr_cnt), 32'h40);
    check(block_order(10'h010, 1'b0), "R3 fill order", 32'(rd_addr_log[0]), 32'h010);
  endtask

  task automatic t_read_hit;
    logic [31:0] rd; bit st, rv;
    access(1'b0, 10'h01C, '0, rd, st, rv);
    check(!st && rd_cnt == 0 && wr_cnt == 0, "R2 hit no stall/traffic", 32'(st), 0);
    check(rv, "R2 rvalid next cycle", 32'(rv), 1);
    check(rd == init_val(10'h01C), "R2 hit data", rd, init_val(10'h01C));
  endtask

  task automatic t_store_hit;
    logic [31:0] rd; bit st, rv;
    access(1'b1, 10'h014, 32'hDEAD_BEEF, rd, st, rv);
    check(!st && wr_cnt == 0, "R4 store hit no stall/write", 32'(st), 0);
    check(mem_model[5] == init_val(10'h014), "R4 memory unchanged", mem_model[5], init_val(10'h014));
    access(1'b0, 10'h014, '0, rd, st, rv);
    check(rd == 32'hDEAD_BEEF, "R4 cached store read back", rd, 32'hDEAD_BEEF);
  endtask

  task automatic t_dirty_evict;
    logic [31:0] rd; bit st, rv;
    access(1'b0, 10'h098, '0, rd, st, rv);
    check(wr_cnt == 4, "R5 dirty line written back", 32'(wr_cnt), 4);
    check(block_order(10'h010, 1'b1), "R5 write-back order/addresses", 32'(wr_addr_log[0]), 32'h010);
    check(wr_data_log[1] == 32'hDEAD_BEEF, "R5 write-back data", wr_data_log[1], 32'hDEAD_BEEF);
    check(rd == init_val(10'h098) && rd_cnt == 4, "R5 fill after write-back", rd, init_val(10'h098));
  endtask

  task automatic t_clean_evict;
    logic [31:0] rd; bit st, rv;
    access(1'b0, 10'h118, '0, rd, st, rv);
    check(st && wr_cnt == 0, "R6 clean victim no write-back", 32'(wr_cnt), 0);
    check(rd == init_val(10'h118), "R1 new tag data", rd, init_val(10'h118));
  endtask

  task automatic t_store_miss;
    logic [31:0] rd; bit st, rv;
    access(1'b1, 10'h234, 32'h1234_5678, rd, st, rv);
    check(st && rd_cnt == 4 && wr_cnt == 0, "R7 store miss fetches block", 32'(rd_cnt), 4);
    access(1'b0, 10'h234, '0, rd, st, rv);
    check(!st && rd == 32'h1234_5678, "R7 merged store word", rd, 32'h1234_5678);
    access(1'b0, 10'h238, '0, rd, st, rv);
    check(rd == init_val(10'h238), "R7 other word from memory", rd, init_val(10'h238));
    access(1'b0, 10'h034, '0, rd, st, rv);
    check(st, "R1 same index other tag misses", 32'(st), 1);
    check(wr_cnt == 4 && mem_model[8'h8D] == 32'h1234_5678, "R7 allocated line dirty",
          mem_model[8'h8D], 32'h1234_5678);
  endtask

  task automatic t_reset_clear;
    logic [31:0] rd; bit st, rv;
    access(1'b1, 10'h038, 32'hCAFE_0001, rd, st, rv);
    check(!st, "R4 store hit on filled line", 32'(st), 0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access(1'b0, 10'h038, '0, rd, st, rv);
    check(st && wr_cnt == 0, "R8 reset drops valid and dirty", 32'(wr_cnt), 0);
    check(rd == init_val(10'h038), "R8 refetched data", rd, init_val(10'h038));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wr_cnt = 0; rd_cnt = 0; hold_viol = 0;
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_read_miss();
    t_read_hit();
    t_store_hit();
    t_dirty_evict();
    t_clean_evict();
    t_store_miss();
    t_reset_clear();
    check(hold_viol == 0, "R9 request held until ack", 32'(hold_viol), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule